// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupts

This block is a memory-mapped general purpose I/O controller for a parameterised number of pins. The pins are grouped into banks of 32. Every function has one 32-bit word per bank, placed at that function's base offset plus four times the bank number. Software drives outputs through separate set and clear ports, so a single write changes only the selected pins and needs no read-modify-write. It chooses the direction of each pin and reads back the synchronised pin levels.

Each pin can raise an interrupt on a rising edge, on a falling edge, or on both. It can instead raise one while it sits at a programmed active level, high or low. Interrupt status and wake status bits are cleared by writing 1 to them. A pin's pending interrupt reaches the single combined interrupt output only when its mask bit is set. Pins enabled for wake also record their events in a separate wake status word.

Top module: `pinbank_gpio`

## Requirements
- R1: The word for pin p of a function sits at base + 4*floor(p/32), bit p mod 32. The bases are: level 0x004, direction 0x01C, set 0x034, clear 0x04C, rising enable 0x064, falling enable 0x07C, mask 0x0AC, status 0x0C4, input type 0x300, polarity 0x318, wake mask 0x400, wake status 0x418. A read issued with bus_rd returns its data on bus_rdata one cycle later. The word at 0x000 and unmapped offsets read zero.
- R2: A write of 1 to a set-port bit drives that pin_out bit high, and a write of 1 to a clear-port bit drives it low. Zero bits leave pin_out unchanged, and both ports read as zero.
- R3: A direction bit of 1 sets the matching pin_oe bit (output), and 0 clears it (input). The direction word reads back as written.
- R4: The level word returns pin_in after a two-flop synchroniser, so a change is visible two clocks after it reaches pin_in. Writes to the level word have no effect.
- R5: With the input-type bit at 0, a rising edge sets the status bit when the rising enable is 1. A falling edge sets it when the falling enable is 1. With both enables set, either edge sets it, and with neither set, no edge sets it.
- R6: With the input-type bit at 1, the status bit is set while the synchronised pin equals the active level: high when the polarity bit is 0, low when it is 1.
- R7: Writing 1 to a status bit clears it, and zero bits leave status unchanged. An acknowledge wins over a detection in the same cycle. A level source that is still active sets the bit again in the next cycle.
- R8: irq is high exactly when some pin has both its status bit and its mask bit at 1. Status is recorded whether or not the pin is masked.
- R9: A pin's interrupt condition sets its wake status bit only when its wake-mask bit is 1. Writing 1 to a wake status bit clears it.
- R10: After reset all outputs, enables, status bits and pin_out, pin_oe and irq are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address of the register word |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data follows one cycle later |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_out | output | NUM_PINS | Output drive values |
| pin_oe | output | NUM_PINS | Output enables (1 = drive) |
| irq | output | 1 | Combined masked interrupt |

## Verification
Every cycle, the assertions check several properties. An acknowledged status bit is clear in the following cycle. A new edge-mode status bit only appears for a pin with an edge enable set. A new wake bit only appears for a wake-enabled pin. A set-port write drives its pin high and a clear-port write drives it low, and a read of the write-only port returns zero. Only the bench's scenarios can show the behaviours that depend on the pin history and register sequences. These are each edge and level mode with each polarity, the re-raise of a level source one cycle after its acknowledge, mask gating of irq, bank addressing of the narrower upper bank, and the synchroniser latency of the level word.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int ADDR_W  = 12;
    localparam int NUM_FN  = 13;
    localparam int BANK_W  = 32;

    // function selector; the numeric order matches the base table below
    typedef enum logic [3:0] {
        FN_CFG   = 4'd0,
        FN_LVL   = 4'd1,
        FN_DIR   = 4'd2,
        FN_SET   = 4'd3,
        FN_CLR   = 4'd4,
        FN_RISE  = 4'd5,
        FN_FALL  = 4'd6,
        FN_MASK  = 4'd7,
        FN_STS   = 4'd8,
        FN_ITYPE = 4'd9,
        FN_POL   = 4'd10,
        FN_WMASK = 4'd11,
        FN_WSTS  = 4'd12
    } fn_e;

    localparam logic [ADDR_W-1:0] FN_BASE [NUM_FN] = '{
        12'h000, 12'h004, 12'h01C, 12'h034, 12'h04C, 12'h064, 12'h07C,
        12'h0AC, 12'h0C4, 12'h300, 12'h318, 12'h400, 12'h418
    };

    typedef struct packed {
        logic       hit;
        fn_e        fn;
        logic [2:0] bank;
    } dec_t;

    // Map a byte address to a function and bank; the configuration word
    // spans one word, every other function spans one word per bank.
    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a,
                                         input int nbanks);
        dec_t r;
        r = '{hit: 1'b0, fn: FN_CFG, bank: 3'd0};
        for (int i = 0; i < NUM_FN; i++) begin
            int span;
            span = (i == 0) ? 1 : nbanks;
            if (a >= FN_BASE[i] && a < FN_BASE[i] + ADDR_W'(4 * span) &&
                a[1:0] == 2'b00) begin
                r.hit  = 1'b1;
                r.fn   = fn_e'(4'(i));
                r.bank = 3'((a - FN_BASE[i]) >> 2);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prev
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d    = q;
        d.s1 = raw;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign lvl  = q.s2;
    assign prev = q.s3;

endmodule

// File: rtl/pinbank_bank.sv
module pinbank_bank
    import pinbank_pkg::*;
#(
    parameter int BW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  fn_e           fn,
    input  logic [BW-1:0] wdata,
    input  logic [BW-1:0] lvl,
    input  logic [BW-1:0] prev,
    output logic [BW-1:0] dir,
    output logic [BW-1:0] out,
    output logic          pend,
    output logic [31:0]   rd_word
);
    typedef struct packed {
        logic [BW-1:0] dir;
        logic [BW-1:0] out;
        logic [BW-1:0] ren;
        logic [BW-1:0] fen;
        logic [BW-1:0] msk;
        logic [BW-1:0] sts;
        logic [BW-1:0] ity;
        logic [BW-1:0] pol;
        logic [BW-1:0] wmk;
        logic [BW-1:0] wak;
    } bank_t;

    bank_t q, d;

    logic [BW-1:0] ack_d, wack_d, edge_hit, lvl_hit, cond, rd_val;

    // detection: edges against the previous synchronised sample, level
    // against the programmed active polarity
    always_comb begin
        edge_hit = (lvl & ~prev & q.ren) | (~lvl & prev & q.fen);
        lvl_hit  = lvl ^ q.pol;
        cond     = (q.ity & lvl_hit) | (~q.ity & edge_hit);
    end

    always_comb begin
        d      = q;
        ack_d  = '0;
        wack_d = '0;
        if (wr_en) begin
            case (fn)
                FN_DIR:   d.dir = wdata;
                FN_SET:   d.out = q.out | wdata;
                FN_CLR:   d.out = q.out & ~wdata;
                FN_RISE:  d.ren = wdata;
                FN_FALL:  d.fen = wdata;
                FN_MASK:  d.msk = wdata;
                FN_STS:   ack_d = wdata;
                FN_ITYPE: d.ity = wdata;
                FN_POL:   d.pol = wdata;
                FN_WMASK: d.wmk = wdata;
                FN_WSTS:  wack_d = wdata;
                default:  ;
            endcase
        end
        // acknowledge wins; a persisting level re-raises one cycle later
        d.sts = (q.sts | cond) & ~ack_d;
        d.wak = (q.wak | (cond & q.wmk)) & ~wack_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (fn)
            FN_LVL:   rd_val = lvl;
            FN_DIR:   rd_val = q.dir;
            FN_RISE:  rd_val = q.ren;
            FN_FALL:  rd_val = q.fen;
            FN_MASK:  rd_val = q.msk;
            FN_STS:   rd_val = q.sts;
            FN_ITYPE: rd_val = q.ity;
            FN_POL:   rd_val = q.pol;
            FN_WMASK: rd_val = q.wmk;
            FN_WSTS:  rd_val = q.wak;
            default:  rd_val = '0;
        endcase
    end

    assign rd_word = 32'(rd_val);
    assign dir     = q.dir;
    assign out     = q.out;
    assign pend    = |(q.sts & q.msk);

    // R7: an acknowledged status bit is clear in the next cycle
    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fn == FN_STS) |=> ((q.sts & $past(wdata)) == '0));

    // R5: a new edge-mode status bit needs an edge enable on that pin
    p_edge_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q.sts & ~$past(q.sts) & ~$past(q.ity)
                   & ~$past(q.ren | q.fen)) == '0));

    // R9: a new wake status bit needs the pin's wake mask
    p_wake_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q.wak & ~$past(q.wak) & ~$past(q.wmk)) == '0));

endmodule

// File: rtl/pinbank_gpio.sv
module pinbank_gpio
    import pinbank_pkg::*;
#(
    parameter int NUM_PINS = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [11:0]         bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    // the register map leaves room for at most six banks (192 pins)
    localparam int NB     = (NUM_PINS + BANK_W - 1) / BANK_W;
    localparam int MAXB   = 8;

    logic [NUM_PINS-1:0] lvl_s, prev_s;
    logic [31:0]         bank_rd [MAXB];
    logic [MAXB-1:0]     bank_pend;
    dec_t                dec;

    typedef struct packed {
        logic [31:0] rdata;
    } top_t;

    top_t q, d;

    pinbank_sync #(.W(NUM_PINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (pin_in),
        .lvl  (lvl_s),
        .prev (prev_s)
    );

    always_comb dec = decode_addr(bus_addr, NB);

    for (genvar b = 0; b < MAXB; b++) begin : g_bank
        if (b < NB) begin : g_on
            localparam int BW = (NUM_PINS - b * BANK_W >= BANK_W)
                                ? BANK_W : NUM_PINS - b * BANK_W;
            pinbank_bank #(.BW(BW)) u_bank (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_en  (bus_wr && dec.hit && dec.bank == 3'(b)),
                .fn     (dec.fn),
                .wdata  (bus_wdata[BW-1:0]),
                .lvl    (lvl_s[b*BANK_W +: BW]),
                .prev   (prev_s[b*BANK_W +: BW]),
                .dir    (pin_oe[b*BANK_W +: BW]),
                .out    (pin_out[b*BANK_W +: BW]),
                .pend   (bank_pend[b]),
                .rd_word(bank_rd[b])
            );
        end else begin : g_off
            assign bank_rd[b]   = '0;
            assign bank_pend[b] = 1'b0;
        end
    end

    always_comb begin
        d = q;
        if (bus_rd) d.rdata = dec.hit ? bank_rd[dec.bank] : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_rdata = q.rdata;
    assign irq       = |bank_pend;

    // R2: a set-port bit drives the pin high on the next cycle
    p_set_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == FN_BASE[FN_SET] && bus_wdata[0]) |=> pin_out[0]);

    // R2: a clear-port bit drives the pin low on the next cycle
    p_clr_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == FN_BASE[FN_CLR] && bus_wdata[0]) |=> !pin_out[0]);

    // R2: write-only ports read back as zero
    p_wo_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == FN_BASE[FN_SET] || bus_addr == FN_BASE[FN_CLR]))
        |=> bus_rdata == 32'd0);

endmodule

// File: tb/pinbank_gpio_test.sv
`timescale 1ns/1ps
module pinbank_gpio_test;

    localparam int NP = 48;
    localparam logic [11:0] A_CFG = 12'h000, A_LVL = 12'h004, A_DIR = 12'h01C,
        A_SET = 12'h034, A_CLR = 12'h04C, A_RISE = 12'h064, A_FALL = 12'h07C,
        A_MASK = 12'h0AC, A_STS = 12'h0C4, A_ITY = 12'h300, A_POL = 12'h318,
        A_WMK = 12'h400, A_WST = 12'h418;
    localparam logic [11:0] B1 = 12'h004;          // bank 1 word step
    localparam logic [31:0] P37 = 32'h0000_0020;   // pin 37 = bank 1 bit 5

    // {rise_en, fall_en, level_type, active_low, start, end, expect}
    localparam logic [6:0] VEC [11] = '{
        7'b1000011, 7'b1000100, 7'b0100101, 7'b0100010, 7'b1100011,
        7'b1100101, 7'b0000010, 7'b0010011, 7'b0011101, 7'b0010000,
        7'b0011110
    };

    logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata, rv;
    logic [NP-1:0] pin_in = '0, pin_out, pin_oe;
    logic irq;
    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pinbank_gpio #(.NUM_PINS(NP)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R10 reset state
        check("R10 pin_out", 64'(pin_out), 64'h0);
        check("R10 pin_oe", 64'(pin_oe), 64'h0);
        check("R10 irq", 64'(irq), 64'h0);
        rd(A_STS, rv);
        check("R10 status", 64'(rv), 64'h0);

        // R2 set / clear ports
        wr(A_SET, 32'h0000_00F0);
        check("R2 set", 64'(pin_out), 64'h0000_0000_00F0);
        wr(A_CLR, 32'h0000_0030);
        check("R2 clear", 64'(pin_out), 64'h0000_0000_00C0);
        rd(A_SET, rv);
        check("R2 set reads zero", 64'(rv), 64'h0);
        rd(A_CLR, rv);
        check("R2 clear reads zero", 64'(rv), 64'h0);
        // R1 bank 1 addressing
        wr(A_SET + B1, 32'h0000_8001);
        check("R1 bank1 set", 64'(pin_out), 64'h8001_0000_00C0);

        // R3 direction
        wr(A_DIR + B1, 32'h5);
        check("R3 pin_oe", 64'(pin_oe), 64'h0005_0000_0000);
        rd(A_DIR + B1, rv);
        check("R3 readback", 64'(rv), 64'h5);

        // R4 level view and its latency
        @(negedge clk);
        pin_in = 48'hA5A5_1234_5678;
        @(negedge clk);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = A_LVL;
        @(negedge clk);
        bus_rd = 1'b0;
        check("R4 latency two clocks", 64'(bus_rdata), 64'h1234_5678);
        rd(A_LVL + B1, rv);
        check("R4 bank1 level", 64'(rv), 64'hA5A5);
        wr(A_LVL, 32'h0);
        rd(A_LVL, rv);
        check("R4 level write ignored", 64'(rv), 64'h1234_5678);
        rd(A_CFG, rv);
        check("R1 config word zero", 64'(rv), 64'h0);
        pin_in = '0;
        idle(4);

        // R5 / R6 table of detection modes on pin 37
        for (int i = 0; i < 11; i++) begin
            wr(A_POL + B1, VEC[i][3] ? P37 : 32'h0);
            wr(A_ITY + B1, VEC[i][4] ? P37 : 32'h0);
            wr(A_RISE + B1, VEC[i][6] ? P37 : 32'h0);
            wr(A_FALL + B1, VEC[i][5] ? P37 : 32'h0);
            pin_in[37] = VEC[i][2];
            idle(5);
            wr(A_STS + B1, P37);
            pin_in[37] = VEC[i][1];
            idle(5);
            rd(A_STS + B1, rv);
            check(VEC[i][4] ? $sformatf("R6 vector %0d", i) : $sformatf("R5 vector %0d", i),
                  64'(rv[5]), 64'(VEC[i][0]));
        end

        // R8 mask gating, R7 acknowledge
        wr(A_POL + B1, 32'h0);
        wr(A_ITY + B1, 32'h0);
        wr(A_FALL + B1, 32'h0);
        wr(A_RISE + B1, P37);
        wr(A_MASK + B1, 32'h0);
        pin_in[37] = 1'b0;
        idle(5);
        wr(A_STS + B1, P37);
        pin_in[37] = 1'b1;
        idle(5);
        check("R8 masked irq low", 64'(irq), 64'h0);
        rd(A_STS + B1, rv);
        check("R8 status recorded while masked", 64'(rv[5]), 64'h1);
        wr(A_MASK + B1, P37);
        check("R8 unmasked irq high", 64'(irq), 64'h1);
        wr(A_STS + B1, 32'h0000_0010);
        check("R7 zero bits keep status", 64'(irq), 64'h1);
        wr(A_STS + B1, P37);
        check("R7 acknowledge clears", 64'(irq), 64'h0);

        // R7 level source re-raises the cycle after acknowledge
        wr(A_ITY + B1, P37);
        idle(3);
        wr(A_STS + B1, P37);
        check("R7 cleared in ack cycle", 64'(irq), 64'h0);
        @(negedge clk);
        check("R7 level re-raise", 64'(irq), 64'h1);
        pin_in[37] = 1'b0;
        wr(A_ITY + B1, 32'h0);
        idle(4);
        wr(A_STS + B1, P37);
        check("R7 cleared after level drop", 64'(irq), 64'h0);

        // R9 wake status
        wr(A_WMK + B1, P37);
        wr(A_WST + B1, P37);
        pin_in[37] = 1'b1;
        idle(5);
        rd(A_WST + B1, rv);
        check("R9 wake set", 64'(rv), 64'(P37));
        wr(A_WST + B1, P37);
        rd(A_WST + B1, rv);
        check("R9 wake ack", 64'(rv), 64'h0);
        wr(A_WMK + B1, 32'h0);
        wr(A_STS + B1, P37);
        pin_in[37] = 1'b0;
        idle(4);
        pin_in[37] = 1'b1;
        idle(5);
        rd(A_WST + B1, rv);
        check("R9 wake gated by mask", 64'(rv), 64'h0);
        rd(A_STS + B1, rv);
        check("R9 status still set", 64'(rv[5]), 64'h1);

        finish_run();
    end

endmodule